// File: doc/BRIEF.md
# Configurable Trigger Match Unit

This block watches one group of probed bus signals and raises a single-cycle event when that group meets a condition chosen at run time. The condition can be a bitwise pattern with don't-care bits, per-bit transitions judged against the sample taken on the previous clock, an unsigned relation against a reference value, or a window test between two bounds. A built-in occurrence counter can hold the event back until the condition has been met a chosen number of times.

A parameter states whether the probed group is a single bus, such as an address or data bus, or a bundle of unrelated control signals. A bundle may only use the two pattern modes. A second parameter sets the width of the occurrence counter. A width of zero removes the counter, and the unit then fires on every hit. The unit is meant to feed a capture or sequencing engine, which then consumes the `matchEvent` pulse.

Top module: `trig_match_unit`

## Requirements
- R1: While `rstN` is low, and on the first clock edge after it rises, `matchEvent` is 0. Reset clears the occurrence count and marks the edge history as empty.
- R2: Mode code 0 is a pattern compare. A bit with `patMask` = 1 must equal its `patValue` bit. A bit with `patMask` = 0 is don't-care. `edgeRise` and `edgeFall` have no effect in even mode codes.
- R3: In mode code 1, a bit with `edgeRise` set requires a 0 to 1 change since the previous sample. A bit with `edgeFall` set requires a 1 to 0 change. A bit with both set accepts either change. Bits with neither set follow the R2 rule.
- R4: Until one sample has been recorded after reset, any edge-select bit in an odd mode code blocks the hit.
- R5: Mode code 2 compares v = `probe & patMask` with r = `patValue & patMask` as unsigned values. The `relOp` codes are 0 equal, 1 not equal, 2 greater, 3 less, 4 greater-or-equal and 5 less-or-equal. Codes 6 and 7 never hit.
- R6: Mode code 4 hits when `rangeLo` ≤ v ≤ `rangeHi`. When `rangeInvert` is 1, it hits when v lies outside that window instead. v is defined as in R5.
- R7: Mode codes 3 and 5 require both the R5 or R6 compare and the edge terms of R3 for every bit that has an edge select.
- R8: Mode codes 6 and 7 never hit. When `SINGLE_BUS` = 0, mode codes 2 to 5 never hit either.
- R9: When `CNT_W` > 0, the event fires on the N-th hit, where N = `occTarget`, and a target of 0 counts as 1. Cycles without a hit leave the count unchanged.
- R10: The count returns to zero when the event fires, so each further event needs N new hits.
- R11: When `CNT_W` = 0, every hit fires the event and `occTarget` is ignored.
- R12: `matchEvent` is registered. It is high in the cycle after the clock edge that sampled the qualifying hit, and for one cycle per target reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| probe | input | W | Probed signal group |
| mode | input | 3 | Compare mode code (0..5 legal) |
| patValue | input | W | Level pattern / relation reference |
| patMask | input | W | 1 = bit is compared |
| edgeRise | input | W | Per-bit rising-edge select |
| edgeFall | input | W | Per-bit falling-edge select |
| relOp | input | 3 | Relation code for extended modes |
| rangeLo | input | W | Lower window bound |
| rangeHi | input | W | Upper window bound |
| rangeInvert | input | 1 | 1 = hit outside the window |
| occTarget | input | max(CNT_W,1) | Occurrence target |
| matchEvent | output | 1 | One-cycle match event |

## Verification
Several properties are checked on every cycle. An event only follows a sampled hit. An illegal mode code is followed by a quiet output. No edge term can hit before history exists. The counter only steps up by one or clears, and it is empty after each event. Only the bench's sweeps can show that each pattern, relation and window result is correct, because the bench compares every probe value against an independently computed expectation. The bench's scripted sequences are likewise the only check of the occurrence counts, including a target of 0 and a restricted group rejecting the wider modes.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

  typedef enum logic [1:0] {
    CLS_PATTERN  = 2'd0,
    CLS_RELATION = 2'd1,
    CLS_WINDOW   = 2'd2,
    CLS_NONE     = 2'd3
  } cmp_class_e;

  typedef enum logic [2:0] {
    REL_EQ = 3'd0,
    REL_NE = 3'd1,
    REL_GT = 3'd2,
    REL_LT = 3'd3,
    REL_GE = 3'd4,
    REL_LE = 3'd5
  } rel_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       cmpEnable;
    logic       edgeMode;
    logic       histOk;
    cmp_class_e cmpClass;
  } dp_ctrl_t;

  localparam logic [2:0] MAX_MODE_CODE   = 3'd5;
  localparam logic [2:0] MAX_BUNDLE_MODE = 3'd1;

endpackage

// File: rtl/tmu_datapath.sv
module tmu_datapath
  import tmu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] probe,
  input  logic [W-1:0] patValue,
  input  logic [W-1:0] patMask,
  input  logic [W-1:0] edgeRise,
  input  logic [W-1:0] edgeFall,
  input  logic [2:0]   relOp,
  input  logic [W-1:0] rangeLo,
  input  logic [W-1:0] rangeHi,
  input  logic         rangeInvert,
  input  dp_ctrl_t     ctrl,
  output logic         hit
);

  logic [W-1:0] prevSample;
  logic [W-1:0] roseBit, fellBit, edgeHit, edgeSel, levelMask;
  logic [W-1:0] maskedVal, maskedRef;
  logic         edgeOk, patternOk, relationOk, windowOk, classOk;

  always_ff @(posedge clk) begin
    if (!rstN) prevSample <= '0;
    else       prevSample <= probe;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign roseBit[b] = ~prevSample[b] & probe[b];
    assign fellBit[b] = prevSample[b] & ~probe[b];
    assign edgeHit[b] = (edgeRise[b] & roseBit[b]) | (edgeFall[b] & fellBit[b]);
    assign edgeSel[b] = edgeRise[b] | edgeFall[b];
  end

  always_comb begin
    if (!ctrl.edgeMode || edgeSel == '0) edgeOk = 1'b1;
    else edgeOk = ctrl.histOk && (&(edgeHit | ~edgeSel));
  end

  assign levelMask = ctrl.edgeMode ? (patMask & ~edgeSel) : patMask;
  assign patternOk = ((probe ^ patValue) & levelMask) == '0;

  assign maskedVal = probe & patMask;
  assign maskedRef = patValue & patMask;

  always_comb begin
    case (relOp)
      REL_EQ:  relationOk = (maskedVal == maskedRef);
      REL_NE:  relationOk = (maskedVal != maskedRef);
      REL_GT:  relationOk = (maskedVal >  maskedRef);
      REL_LT:  relationOk = (maskedVal <  maskedRef);
      REL_GE:  relationOk = (maskedVal >= maskedRef);
      REL_LE:  relationOk = (maskedVal <= maskedRef);
      default: relationOk = 1'b0;
    endcase
  end

  assign windowOk = ((maskedVal >= rangeLo) && (maskedVal <= rangeHi)) ^ rangeInvert;

  always_comb begin
    case (ctrl.cmpClass)
      CLS_PATTERN:  classOk = patternOk;
      CLS_RELATION: classOk = relationOk;
      CLS_WINDOW:   classOk = windowOk;
      default:      classOk = 1'b0;
    endcase
  end

  assign hit = ctrl.cmpEnable && edgeOk && classOk;

  // R4: edge selects cannot be satisfied before a history sample exists
  assert_no_edge_without_history_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.edgeMode && !ctrl.histOk && (edgeSel != '0)) |-> !hit);

  // R6: a non-inverted window hit lies inside the bounds
  assert_window_inside_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hit && ctrl.cmpClass == CLS_WINDOW && !rangeInvert) |->
      ((probe & patMask) >= rangeLo && (probe & patMask) <= rangeHi));

endmodule

// File: rtl/tmu_control.sv
module tmu_control
  import tmu_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter bit SINGLE_BUS = 1'b1,
  localparam int TGT_W     = (CNT_W == 0) ? 1 : CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       mode,
  input  logic [TGT_W-1:0] occTarget,
  input  logic             hitIn,
  output dp_ctrl_t         ctrl,
  output logic             matchEvent
);

  logic modeLegal;
  logic histValid;
  logic eventNext;

  always_comb begin
    modeLegal = (mode <= MAX_MODE_CODE);
    if (!SINGLE_BUS && mode > MAX_BUNDLE_MODE) modeLegal = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) histValid <= 1'b0;
    else       histValid <= 1'b1;
  end

  always_comb begin
    ctrl.cmpEnable = modeLegal;
    ctrl.edgeMode  = mode[0];
    ctrl.histOk    = histValid;
    ctrl.cmpClass  = modeLegal ? cmp_class_e'(mode[2:1]) : CLS_NONE;
  end

  if (CNT_W == 0) begin : g_nocount
    logic unusedTarget;
    assign unusedTarget = ^occTarget;
    assign eventNext    = hitIn;
  end else begin : g_count
    logic [CNT_W-1:0] occCnt;
    logic [CNT_W-1:0] tgtEff;
    logic [CNT_W:0]   cntPlusOne;
    logic             reached;

    assign tgtEff     = (occTarget == '0) ? CNT_W'(1) : occTarget;
    assign cntPlusOne = {1'b0, occCnt} + (CNT_W+1)'(1);
    assign reached    = cntPlusOne >= {1'b0, tgtEff};
    assign eventNext  = hitIn && reached;

    always_ff @(posedge clk) begin
      if (!rstN)        occCnt <= '0;
      else if (hitIn) begin
        if (reached)    occCnt <= '0;
        else            occCnt <= cntPlusOne[CNT_W-1:0];
      end
    end

    // R10: the count is empty whenever the event is presented
    assert_count_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
      matchEvent |-> (occCnt == '0));

    // R9: the count only steps by one or returns to zero
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rstN)
      (occCnt != $past(occCnt)) |->
        (occCnt == '0 || occCnt == $past(occCnt) + CNT_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) matchEvent <= 1'b0;
    else       matchEvent <= eventNext;
  end

  // R12: an event is always the registered image of a sampled hit
  assert_event_after_hit_R12: assert property (@(posedge clk) disable iff (!rstN)
    matchEvent |-> $past(hitIn));

  // R8: an unusable mode code is never followed by an event
  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mode > MAX_MODE_CODE) |=> !matchEvent);

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import tmu_pkg::*;
#(
  parameter int W          = 8,
  parameter int CNT_W      = 4,
  parameter bit SINGLE_BUS = 1'b1,
  localparam int TGT_W     = (CNT_W == 0) ? 1 : CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [W-1:0]     probe,
  input  logic [2:0]       mode,
  input  logic [W-1:0]     patValue,
  input  logic [W-1:0]     patMask,
  input  logic [W-1:0]     edgeRise,
  input  logic [W-1:0]     edgeFall,
  input  logic [2:0]       relOp,
  input  logic [W-1:0]     rangeLo,
  input  logic [W-1:0]     rangeHi,
  input  logic             rangeInvert,
  input  logic [TGT_W-1:0] occTarget,
  output logic             matchEvent
);

  dp_ctrl_t ctrl;
  logic     hit;

  tmu_control #(.CNT_W(CNT_W), .SINGLE_BUS(SINGLE_BUS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mode       (mode),
    .occTarget  (occTarget),
    .hitIn      (hit),
    .ctrl       (ctrl),
    .matchEvent (matchEvent)
  );

  tmu_datapath #(.W(W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .probe       (probe),
    .patValue    (patValue),
    .patMask     (patMask),
    .edgeRise    (edgeRise),
    .edgeFall    (edgeFall),
    .relOp       (relOp),
    .rangeLo     (rangeLo),
    .rangeHi     (rangeHi),
    .rangeInvert (rangeInvert),
    .ctrl        (ctrl),
    .hit         (hit)
  );

endmodule

// File: tb/tb_trig_match_unit.sv
module tb_trig_match_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] probe = '0;
  logic [2:0] mode = '0;
  logic [3:0] patValue = '0, patMask = '0, edgeRise = '0, edgeFall = '0;
  logic [2:0] relOp = '0;
  logic [3:0] rangeLo = '0, rangeHi = '0;
  logic       rangeInvert = 1'b0;
  logic [1:0] tgt = 2'd1;
  logic       ev1, ev2;

  int checks = 0, errors = 0;
  logic [3:0] prevM = '0;
  logic       histM = 1'b0;
  int         cntM  = 0;

  always #2 clk = ~clk;

  trig_match_unit #(.W(4), .CNT_W(2), .SINGLE_BUS(1'b1)) dut (
    .clk(clk), .rstN(rstN), .probe(probe), .mode(mode), .patValue(patValue),
    .patMask(patMask), .edgeRise(edgeRise), .edgeFall(edgeFall), .relOp(relOp),
    .rangeLo(rangeLo), .rangeHi(rangeHi), .rangeInvert(rangeInvert),
    .occTarget(tgt), .matchEvent(ev1));

  trig_match_unit #(.W(4), .CNT_W(0), .SINGLE_BUS(1'b0)) dutBundle (
    .clk(clk), .rstN(rstN), .probe(probe), .mode(mode), .patValue(patValue),
    .patMask(patMask), .edgeRise(edgeRise), .edgeFall(edgeFall), .relOp(relOp),
    .rangeLo(rangeLo), .rangeHi(rangeHi), .rangeInvert(rangeInvert),
    .occTarget(1'b1), .matchEvent(ev2));

  function automatic logic modelHit(input logic [3:0] p, input logic [3:0] pr,
                                    input logic hv, input logic single);
    logic ok;
    logic [3:0] v, r;
    int cls;
    if (mode > 3'd5) return 1'b0;
    if (!single && mode > 3'd1) return 1'b0;
    ok  = 1'b1;
    cls = int'(mode) / 2;
    for (int i = 0; i < 4; i++) begin
      if (mode[0] && (edgeRise[i] || edgeFall[i])) begin
        if (!hv) ok = 1'b0;
        else if (!((edgeRise[i] && !pr[i] && p[i]) || (edgeFall[i] && pr[i] && !p[i]))) ok = 1'b0;
      end else if (cls == 0 && patMask[i] && p[i] != patValue[i]) ok = 1'b0;
    end
    v = p & patMask;
    r = patValue & patMask;
    if (cls == 1) begin
      case (relOp)
        3'd0: ok &= (v == r);
        3'd1: ok &= (v != r);
        3'd2: ok &= (v > r);
        3'd3: ok &= (v < r);
        3'd4: ok &= (v >= r);
        3'd5: ok &= (v <= r);
        default: ok = 1'b0;
      endcase
    end
    if (cls == 2) ok &= ((v >= rangeLo && v <= rangeHi) != rangeInvert);
    return ok;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: matchEvent=%0b expected %0b (probe=%h prev=%h mode=%0d)",
               tag, act, exp, probe, prevM, mode);
    end
  endtask

  task automatic step(input logic [3:0] p, input string tag);
    logic h1, h2, e1;
    int t;
    probe = p;
    h1 = modelHit(p, prevM, histM, 1'b1);
    h2 = modelHit(p, prevM, histM, 1'b0);
    t  = (tgt == 2'd0) ? 1 : int'(tgt);
    e1 = 1'b0;
    if (h1) begin
      if (cntM + 1 >= t) begin e1 = 1'b1; cntM = 0; end
      else cntM++;
    end
    @(posedge clk); #1;
    check(ev1, e1, tag);
    check(ev2, h2, (mode > 3'd1) ? "R8" : "R11");
    prevM = p;
    histM = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset holds the event low even with an always-hit pattern
    mode = 3'd0; patMask = 4'h0;
    repeat (3) begin
      @(posedge clk); #1;
      check(ev1, 1'b0, "R1");
      check(ev2, 1'b0, "R1");
    end
    // R4: first sample after reset cannot satisfy an edge select
    mode = 3'd1; edgeRise = 4'b0001; patMask = 4'h0;
    rstN = 1'b1;
    step(4'h1, "R4");
    step(4'h0, "R3");
    step(4'h1, "R3");

    // R2: pattern sweep
    mode = 3'd0; edgeRise = 4'hF; edgeFall = 4'h3; tgt = 2'd1;
    for (int m = 0; m < 16; m++)
      for (int v = 0; v < 16; v++) begin
        patMask = 4'(m); patValue = 4'(v);
        for (int p = 0; p < 16; p++) step(4'(p), "R2");
      end

    // R3: per-bit edges
    mode = 3'd1; patMask = 4'b0101; patValue = 4'b0100; edgeFall = 4'h0;
    for (int r = 0; r < 16; r++)
      for (int f = 0; f < 4; f++) begin
        edgeRise = 4'(r);
        edgeFall = (f == 0) ? 4'h0 : (f == 1) ? 4'h3 : (f == 2) ? 4'hC : 4'hF;
        for (int p = 0; p < 16; p++) step(4'((p * 7) % 16), "R3");
      end

    // R5: relations, including unused codes
    mode = 3'd2; edgeRise = 4'hF; edgeFall = 4'hF;
    for (int o = 0; o < 8; o++)
      for (int v = 0; v < 16; v++)
        for (int k = 0; k < 2; k++) begin
          relOp = 3'(o); patValue = 4'(v); patMask = (k == 0) ? 4'hF : 4'h6;
          for (int p = 0; p < 16; p++) step(4'(p), "R5");
        end

    // R6: window, normal and inverted
    mode = 3'd4; patMask = 4'hF;
    for (int inv = 0; inv < 2; inv++)
      for (int lo = 0; lo < 16; lo++)
        for (int hi = 0; hi < 16; hi++) begin
          rangeInvert = 1'(inv); rangeLo = 4'(lo); rangeHi = 4'(hi);
          for (int p = 0; p < 16; p += 3) step(4'(p), "R6");
        end
    patMask = 4'b1100; rangeInvert = 1'b0; rangeLo = 4'h4; rangeHi = 4'h8;
    for (int p = 0; p < 16; p++) step(4'(p), "R6");

    // R7: relation and window with edges
    mode = 3'd3; patMask = 4'hF; relOp = 3'd4; patValue = 4'h8;
    edgeRise = 4'b0001; edgeFall = 4'h0;
    for (int n = 0; n < 2; n++)
      for (int p = 0; p < 16; p++) step(4'(p), "R7");
    mode = 3'd5; rangeLo = 4'h4; rangeHi = 4'hB; rangeInvert = 1'b0;
    edgeRise = 4'h0; edgeFall = 4'b1000;
    for (int p = 15; p >= 0; p--) step(4'(p), "R7");
    for (int p = 0; p < 16; p++) step(4'((p * 5) % 16), "R7");

    // R8: unusable mode codes
    edgeRise = 4'h0; edgeFall = 4'h0; patMask = 4'h0;
    for (int md = 6; md < 8; md++) begin
      mode = 3'(md);
      for (int p = 0; p < 16; p++) step(4'(p), "R8");
    end

    // R9 / R10 / R12: occurrence counting
    mode = 3'd0; patMask = 4'b0001; patValue = 4'b0001; tgt = 2'd3;
    step(4'h1, "R9"); step(4'h0, "R9"); step(4'h1, "R9"); step(4'h0, "R9");
    step(4'h0, "R9"); step(4'h1, "R9");
    step(4'h1, "R10"); step(4'h1, "R10"); step(4'h1, "R10");
    tgt = 2'd2;
    step(4'h1, "R12"); step(4'h1, "R12"); step(4'h1, "R12"); step(4'h1, "R12");
    tgt = 2'd0;
    step(4'h1, "R9"); step(4'h0, "R9"); step(4'h1, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule